// File: doc/BRIEF.md
# Receive Acquisition Mode Sequencer

This block is the control sequencer for the front end of a GMSK receiver. It drives two acquire lines: one clamps the level-measurement circuit, the other widens the clock-recovery PLL. It also reports the PLL bandwidth phase and the level-measure mode. All timing is counted in bit periods, taken from a one-cycle bit strobe that the recovered bit clock provides.

Two policies are supported. When a carrier-detect indication is available, the sequencer waits a short delay after carrier appears and then raises both acquire lines. It holds them for a minimum window and waits for an external lock confirmation. Once released, it moves the PLL from wide to medium and, after a fixed interval, to narrow. When no carrier indication exists, both lines are raised as soon as a signal is expected. Lock confirmation then drops only the PLL line, and the level clamp stays on. A channel change restarts everything. A hold request freezes the sequencer. A hold that lasted long enough causes a short re-clamp of the level circuit when the hold is released.

Top module: `rx_acq_seq`

## Requirements
- R1: After reset, dc_acq and pll_acq are 0, pll_bw is 2'b00 (wide) and lvl_avg is 0 (fast peak detect).
- R2: With mode_nocd=0, once carrier is high the sequencer counts DLY_BITS bit strobes. In the cycle after the last of them, dc_acq and pll_acq go to 1 while pll_bw stays 2'b00. Before that, both lines stay 0.
- R3: Once raised, pll_acq and dc_acq stay high until at least MIN_ACQ bit strobes have been counted. A lock_ok that arrives before the window is complete is ignored. After the window, lock_ok releases both lines in the next cycle.
- R4: After release with mode_nocd=0, lvl_avg is 1 and pll_bw is 2'b01 (medium). After MED_BITS further bit strobes, pll_bw becomes 2'b10 (narrow).
- R5: With mode_nocd=1, expect_sig raises both lines in the next cycle, and carrier has no effect. After the window, lock_ok drops only pll_acq. dc_acq stays 1 and lvl_avg stays 0, and pll_bw follows the same medium-then-narrow timing as R4.
- R6: A chan_chg pulse forces dc_acq=0, pll_acq=0 and pll_bw=2'b00 in the next cycle, and the acquisition restarts from the idle state.
- R7: With mode_nocd=0, loss of carrier in any non-idle state returns the sequencer to idle with both lines low in the next cycle.
- R8: While hold is 1, all bit-period counters and the sequencer state are frozen, and the outputs keep their values.
- R9: If hold has been high for at least LONG_HOLD bit strobes, dc_acq is 1 from the cycle after hold falls until the next bit strobe is taken. During that pulse lvl_avg is 0.
- R10: A hold shorter than LONG_HOLD bit strobes causes no re-clamp pulse on dc_acq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per bit period |
| mode_nocd | input | 1 | 1 = no carrier indication policy, 0 = carrier-detect policy |
| carrier | input | 1 | Carrier detected (level) |
| expect_sig | input | 1 | Signal expected (level, no-carrier policy) |
| lock_ok | input | 1 | External lock confirmation |
| chan_chg | input | 1 | Channel change pulse, restarts acquisition |
| hold | input | 1 | Freeze request |
| dc_acq | output | 1 | Level-clamp acquire line |
| pll_acq | output | 1 | PLL acquire line |
| pll_bw | output | 2 | PLL bandwidth phase: 00 wide, 01 medium, 10 narrow |
| lvl_avg | output | 1 | 1 = averaging peak detect, 0 = fast peak detect |

## Verification
The bench builds the sequencer with DLY_BITS=2, MIN_ACQ=4, MED_BITS=5 and LONG_HOLD=8. These small values make every timing boundary reachable in a few dozen bit strobes. The bench sweeps the arrival of lock confirmation over every strobe position from zero to two past the acquire window, so both early-ignored and accepted releases are covered. It also sweeps the hold length from zero to one past the long-hold threshold, which exercises both sides of the re-clamp decision. A long hold placed in the medium phase shows that the medium interval resumes from where it was frozen rather than expiring.

// File: rtl/rx_acq_seq.sv
`timescale 1ns/1ps
module rx_acq_seq #(
  parameter int DLY_BITS  = 2,
  parameter int MIN_ACQ   = 16,
  parameter int MED_BITS  = 30,
  parameter int LONG_HOLD = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       mode_nocd,
  input  logic       carrier,
  input  logic       expect_sig,
  input  logic       lock_ok,
  input  logic       chan_chg,
  input  logic       hold,
  output logic       dc_acq,
  output logic       pll_acq,
  output logic [1:0] pll_bw,
  output logic       lvl_avg
);
  localparam int MX1  = (MIN_ACQ > DLY_BITS) ? MIN_ACQ : DLY_BITS;
  localparam int CMAX = (MED_BITS > MX1) ? MED_BITS : MX1;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int HW   = $clog2(LONG_HOLD + 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_ACQ, S_MED, S_NAR} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [HW-1:0] hcnt;
  logic          hold_q, reclamp;
  logic          tracking;

  assign tracking = (st == S_MED) || (st == S_NAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      hcnt    <= '0;
      hold_q  <= 1'b0;
      reclamp <= 1'b0;
    end else if (chan_chg) begin
      st      <= S_IDLE;
      cnt     <= '0;
      hcnt    <= '0;
      hold_q  <= hold;
      reclamp <= 1'b0;
    end else begin
      hold_q <= hold;
      if (hold) begin
        if (bit_en && hcnt != HW'(LONG_HOLD)) hcnt <= hcnt + 1'b1;
      end else begin
        hcnt <= '0;
        if (hold_q && hcnt == HW'(LONG_HOLD)) reclamp <= 1'b1;
        else if (bit_en)                      reclamp <= 1'b0;
        if (!mode_nocd && !carrier && st != S_IDLE) begin
          st  <= S_IDLE;
          cnt <= '0;
        end else begin
          case (st)
            S_IDLE: if (mode_nocd ? expect_sig : carrier) begin
              st  <= mode_nocd ? S_ACQ : S_WAIT;
              cnt <= '0;
            end
            S_WAIT: if (bit_en) begin
              if (cnt == CW'(DLY_BITS - 1)) begin
                st  <= S_ACQ;
                cnt <= '0;
              end else cnt <= cnt + 1'b1;
            end
            S_ACQ: begin
              if (cnt == CW'(MIN_ACQ) && lock_ok) begin
                st  <= S_MED;
                cnt <= '0;
              end else if (bit_en && cnt != CW'(MIN_ACQ)) cnt <= cnt + 1'b1;
            end
            S_MED: if (bit_en) begin
              if (cnt == CW'(MED_BITS - 1)) begin
                st  <= S_NAR;
                cnt <= '0;
              end else cnt <= cnt + 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign pll_acq = (st == S_ACQ);
  assign dc_acq  = (st == S_ACQ) || reclamp || (mode_nocd && tracking);
  assign pll_bw  = (st == S_MED) ? 2'b01 : (st == S_NAR) ? 2'b10 : 2'b00;
  assign lvl_avg = tracking && !dc_acq;

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chan_chg) |-> (!dc_acq && !pll_acq && pll_bw == 2'b00));

  assert_pll_needs_dc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pll_acq |-> dc_acq);

  assert_release_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_acq) |-> ($past(lock_ok) || $past(chan_chg) || $past(!mode_nocd && !carrier)));

  assert_hold_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hold) && !$past(chan_chg)) |-> ($stable(pll_acq) && $stable(pll_bw)));

  assert_narrow_after_medium_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_bw == 2'b10) |-> $past(pll_bw == 2'b01));
endmodule

// File: tb/sim_rx_acq_seq.sv
`timescale 1ns/1ps
module sim_rx_acq_seq;
  localparam int DLY = 2, MINA = 4, MEDB = 5, LH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, bit_en = 1'b0, mode_nocd = 1'b0, carrier = 1'b0;
  logic expect_sig = 1'b0, lock_ok = 1'b0, chan_chg = 1'b0, hold = 1'b0;
  logic dc_acq, pll_acq, lvl_avg;
  logic [1:0] pll_bw;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_acq_seq #(.DLY_BITS(DLY), .MIN_ACQ(MINA), .MED_BITS(MEDB), .LONG_HOLD(LH)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mode_nocd(mode_nocd),
    .carrier(carrier), .expect_sig(expect_sig), .lock_ok(lock_ok),
    .chan_chg(chan_chg), .hold(hold), .dc_acq(dc_acq), .pll_acq(pll_acq),
    .pll_bw(pll_bw), .lvl_avg(lvl_avg));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic restart();
    chan_chg = 1'b1;
    @(negedge clk);
    chan_chg = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_lock();
    lock_ok = 1'b1;
    @(negedge clk);
    lock_ok = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dc_acq", dc_acq, 0);
    chk("R1 pll_acq", pll_acq, 0);
    chk("R1 pll_bw", pll_bw, 0);
    chk("R1 lvl_avg", lvl_avg, 0);

    carrier = 1'b1;
    @(negedge clk);
    chk("R2 dc before delay", dc_acq, 0);
    strobe(DLY - 1);
    chk("R2 pll before delay", pll_acq, 0);
    strobe(1);
    chk("R2 dc after delay", dc_acq, 1);
    chk("R2 pll after delay", pll_acq, 1);
    chk("R2 bw wide", pll_bw, 0);

    for (int k = 0; k <= MINA + 2; k++) begin
      restart();
      chk("R6 restart clears dc", dc_acq, 0);
      strobe(DLY);
      chk("R2 reacquire", pll_acq, 1);
      strobe(k);
      pulse_lock();
      chk("R3 lock sweep pll", pll_acq, (k < MINA) ? 1 : 0);
      chk("R3 lock sweep dc", dc_acq, (k < MINA) ? 1 : 0);
      if (k < MINA) begin
        strobe(MINA - k);
        chk("R3 still held", pll_acq, 1);
        pulse_lock();
        chk("R3 released", pll_acq, 0);
      end
      chk("R4 lvl_avg", lvl_avg, 1);
      chk("R4 medium", pll_bw, 1);
      strobe(MEDB - 1);
      chk("R4 medium held", pll_bw, 1);
      strobe(1);
      chk("R4 narrow", pll_bw, 2);
    end

    chan_chg = 1'b1;
    @(negedge clk);
    chk("R6 bw wide", pll_bw, 0);
    chk("R6 pll low", pll_acq, 0);
    chan_chg = 1'b0;
    @(negedge clk);
    strobe(DLY);
    chk("R7 in acquire", pll_acq, 1);
    carrier = 1'b0;
    @(negedge clk);
    chk("R7 carrier loss dc", dc_acq, 0);
    chk("R7 carrier loss pll", pll_acq, 0);
    carrier = 1'b1;
    @(negedge clk);
    strobe(DLY);
    strobe(MINA);
    pulse_lock();
    strobe(2);
    hold = 1'b1;
    @(negedge clk);
    strobe(LH + 2);
    chk("R8 bw frozen", pll_bw, 1);
    chk("R8 lvl frozen", lvl_avg, 1);
    hold = 1'b0;
    @(negedge clk);
    chk("R9 reclamp dc", dc_acq, 1);
    chk("R9 lvl fast in clamp", lvl_avg, 0);
    strobe(1);
    chk("R9 reclamp ends", dc_acq, 0);
    strobe(1);
    chk("R8 medium resumed", pll_bw, 1);
    strobe(1);
    chk("R8 narrow after resume", pll_bw, 2);

    for (int len = 0; len <= LH + 1; len++) begin
      hold = 1'b1;
      strobe(len);
      chk("R8 dc frozen in hold", dc_acq, 0);
      hold = 1'b0;
      @(negedge clk);
      if (len >= LH) chk("R9 long hold reclamp", dc_acq, 1);
      else           chk("R10 short hold no reclamp", dc_acq, 0);
      strobe(1);
      chk("R9 pulse cleared", dc_acq, 0);
    end

    mode_nocd = 1'b1;
    carrier = 1'b0;
    restart();
    chk("R5 idle without expect", dc_acq, 0);
    expect_sig = 1'b1;
    @(negedge clk);
    chk("R5 dc up", dc_acq, 1);
    chk("R5 pll up", pll_acq, 1);
    strobe(MINA);
    pulse_lock();
    chk("R5 pll dropped", pll_acq, 0);
    chk("R5 dc kept", dc_acq, 1);
    chk("R5 lvl fast", lvl_avg, 0);
    chk("R5 medium", pll_bw, 1);
    strobe(MEDB);
    chk("R5 narrow", pll_bw, 2);
    chk("R5 dc still high", dc_acq, 1);

    finish_run();
  end
endmodule